// File: doc/BRIEF.md
# Double-Buffered Calendar Register Window

This block places eight timekeeping registers at the eight highest byte addresses of a byte-wide memory space and backs every lower address with an internal SRAM array. Software sees a user copy of the time registers, not the live calendar counters. Once per second, one cycle after the counters advance, the user copy is refreshed from the counters unless a halt is active. Software therefore reads a coherent set of fields without racing the counter update.

Two control bits in the century register govern the copy. With the read-halt bit set, the user copy freezes while the external counters keep running, so no time is lost. With the write-halt bit set, software writes new BCD values into the copy. Clearing the write-halt bit then emits a one-cycle load pulse that carries those values to the counters. The seconds register holds an oscillator-stop bit that gates the once-per-second advance. The day register holds a frequency-test bit that exposes the 512 Hz prescaler phase on the seconds LSB, and a battery-good flag that cannot be written. The block divides an external 512 Hz tick into the advance pulse it gives to the calendar counter, and it takes the counter's present value back as a snapshot.

Top module: `rtcw_window`

## Requirements
- R1: Window offset k (address = all ones in bits ADDR_W-1..3, k in bits 2..0) selects register k in this order: 0 century, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. All lower addresses read and write an SRAM. Read data is valid one cycle after the read strobe.
- R2: After reset the user registers are zero, the day register reads 0x80 when the battery input is good, and neither the load pulse nor the advance pulse is asserted.
- R3: With both halt bits 0, the cycle after each advance pulse copies the counter snapshot into each register's value field. The value masks per offset 0..7 are 0x3F, 0x7F, 0x7F, 0x3F, 0x07, 0x3F, 0x1F, 0xFF.
- R4: While century bit 6 (read halt) is 1, the value fields do not change and advance pulses continue. After the bit clears, the next advance refreshes the copy.
- R5: While century bit 7 (write halt) is 1, written values stay in the copy. A write that clears bit 7 raises the load output for exactly one cycle, starting the cycle after the write. The load carries the masked registers, with byte k at bits 8k+7..8k. This holds even when bit 6 is still set. A century write with bit 7 already 0 produces no load.
- R6: While seconds bit 7 is 1, no advance pulse is produced.
- R7: With day bit 6 at 1 and the oscillator running, seconds bit 0 reads the prescaler phase, which toggles on every 512 Hz tick.
- R8: Day bit 7 always reads the battery-good input. Writes to it have no visible effect.
- R9: Register bits that are outside the value mask and are not control bits (hours 7..6, date 7..6, and others) keep what was written across refreshes.
- R10: One advance pulse, one cycle long, is produced for every DIV counted ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| tick_512 | input | 1 | One-cycle pulse at 512 Hz |
| batt_ok | input | 1 | Battery-good status |
| ctr_now | input | 64 | Calendar counter snapshot, byte k = register k |
| ctr_adv | output | 1 | Once-per-second advance to the counter |
| ctr_load | output | 1 | One-cycle load strobe to the counter |
| ctr_load_val | output | 64 | Values to load, byte k = register k |

## Verification
The bench targets the halt interplay. It checks that a frozen copy stays fixed while the counter model moves on, so a design that refreshed during a read halt would show a changed seconds value. It checks that clearing the write bit with the read bit still set must load, so a design that let the read bit win would never issue the load. It also checks that the copy is refreshed only after the counter has advanced, so a design that sampled in the same cycle would lag one second behind. Spare bits surviving a refresh, the stopped oscillator gating the advance, and the unwritable battery flag are each probed through reads at the bus.

// File: rtl/rtcw_pkg.sv
package rtcw_pkg;
    localparam int NREG = 8;

    localparam logic [2:0] IDX_CENT = 3'd0;
    localparam logic [2:0] IDX_SEC  = 3'd1;
    localparam logic [2:0] IDX_DAY  = 3'd4;

    localparam int CENT_RHALT = 6;
    localparam int CENT_WHALT = 7;
    localparam int SEC_STOP   = 7;
    localparam int DAY_FTEST  = 6;
    localparam int DAY_BATT   = 7;

    // value field of each register; the rest are control or spare bits
    function automatic logic [7:0] reg_mask(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h3F;
            3'd1:    return 8'h7F;
            3'd2:    return 8'h7F;
            3'd3:    return 8'h3F;
            3'd4:    return 8'h07;
            3'd5:    return 8'h3F;
            3'd6:    return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/rtcw_sram.sv
module rtcw_sram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata_q <= mem[addr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/rtcw_prescale.sv
module rtcw_prescale #(
    parameter int DIV = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic sec_pulse,
    output logic phase
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run && tick) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign sec_pulse = run && tick && (cnt_q == LAST);
    assign phase     = cnt_q[0];
endmodule

// File: rtl/rtcw_window.sv
module rtcw_window
    import rtcw_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DIV    = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic              tick_512,
    input  logic              batt_ok,
    input  logic [63:0]       ctr_now,
    output logic              ctr_adv,
    output logic              ctr_load,
    output logic [63:0]       ctr_load_val
);
    localparam int HI_W = ADDR_W - 3;

    typedef struct packed {
        logic [NREG-1:0][7:0] regs;
        logic                 load;
        logic [NREG-1:0][7:0] load_val;
        logic                 refresh;
        logic                 win_hit;
        logic [7:0]           win_data;
    } win_state_t;

    win_state_t s_d, s_q;

    logic             win_sel;
    logic [2:0]       idx;
    logic             halt;
    logic             osc_run;
    logic             ft_on;
    logic             phase;
    logic             adv;
    logic [7:0]       sram_q;
    logic [NREG*8-1:0] user_vals;

    assign win_sel = (bus_addr[ADDR_W-1:3] == {HI_W{1'b1}});
    assign idx     = bus_addr[2:0];
    assign halt    = s_q.regs[IDX_CENT][CENT_RHALT] | s_q.regs[IDX_CENT][CENT_WHALT];
    assign osc_run = ~s_q.regs[IDX_SEC][SEC_STOP];
    assign ft_on   = s_q.regs[IDX_DAY][DAY_FTEST];

    rtcw_prescale #(.DIV(DIV)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (osc_run),
        .tick     (tick_512),
        .sec_pulse(adv),
        .phase    (phase)
    );

    rtcw_sram #(.AW(ADDR_W), .DW(8)) u_sram (
        .clk  (clk),
        .we   (bus_wr && !win_sel),
        .addr (bus_addr),
        .wdata(bus_wdata),
        .rdata(sram_q)
    );

    always_comb begin
        s_d          = s_q;
        s_d.load     = 1'b0;
        s_d.refresh  = adv;
        s_d.win_hit  = bus_rd && win_sel;

        // refresh one cycle after the advance, once the counter has moved
        if (s_q.refresh && !halt) begin
            for (int k = 0; k < NREG; k++) begin
                s_d.regs[k] = (ctr_now[k*8 +: 8] & reg_mask(3'(k)))
                            | (s_q.regs[k] & ~reg_mask(3'(k)));
            end
        end

        if (bus_wr && win_sel) begin
            s_d.regs[idx] = bus_wdata;
            if (idx == IDX_CENT && s_q.regs[IDX_CENT][CENT_WHALT] && !bus_wdata[CENT_WHALT]) begin
                s_d.load = 1'b1;
                for (int k = 0; k < NREG; k++) begin
                    s_d.load_val[k] = s_d.regs[k] & reg_mask(3'(k));
                end
            end
        end

        if (bus_rd && win_sel) begin
            if (idx == IDX_DAY) begin
                s_d.win_data = {batt_ok, s_q.regs[IDX_DAY][6:0]};
            end else if (idx == IDX_SEC && ft_on && osc_run) begin
                s_d.win_data = {s_q.regs[IDX_SEC][7:1], phase};
            end else begin
                s_d.win_data = s_q.regs[idx];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        for (int k = 0; k < NREG; k++) begin
            user_vals[k*8 +: 8] = s_q.regs[k] & reg_mask(3'(k));
        end
    end

    assign bus_rdata    = s_q.win_hit ? s_q.win_data : sram_q;
    assign ctr_adv      = adv;
    assign ctr_load     = s_q.load;
    assign ctr_load_val = s_q.load_val;
endmodule

// File: rtl/rtcw_window_chk.sv
module rtcw_window_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic              batt_ok,
    input logic              ctr_adv,
    input logic              ctr_load,
    input logic              osc_run,
    input logic              halt,
    input logic [63:0]       user_vals
);
    // R4
    frozen_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !bus_wr) |=> $stable(user_vals));

    // R5
    load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_load |=> !ctr_load);

    // R6
    stopped_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |-> !ctr_adv);

    // R8
    batt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_rd) && ($past(bus_addr) == {{(ADDR_W-3){1'b1}}, 3'd4}))
        |-> (bus_rdata[7] == $past(batt_ok)));

    // R10
    adv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_adv |=> !ctr_adv);
endmodule

bind rtcw_window rtcw_window_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .batt_ok  (batt_ok),
    .ctr_adv  (ctr_adv),
    .ctr_load (ctr_load),
    .osc_run  (osc_run),
    .halt     (halt),
    .user_vals(user_vals)
);

// File: tb/test_rtcw_window.sv
module test_rtcw_window;
    localparam int AW  = 10;
    localparam int DIV = 16;
    localparam int TPER = 4;
    localparam logic [AW-1:0] WBASE = 10'h3F8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_rdata;
    logic          tick_512 = 1'b0;
    logic          batt_ok = 1'b1;
    logic [63:0]   ctr_now;
    logic          ctr_adv;
    logic          ctr_load;
    logic [63:0]   ctr_load_val;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    bit tick_en = 0;
    int tdiv    = 0;
    int adv_cnt = 0;
    int tick_cnt = 0;
    int cyc = 0;
    int last_adv = 0;
    int adv_gap = 0;
    logic [7:0] mdl [8];

    always #5 clk = ~clk;

    rtcw_window #(.ADDR_W(AW), .DIV(DIV)) i_rtcw_window (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tick_512(tick_512), .batt_ok(batt_ok), .ctr_now(ctr_now),
        .ctr_adv(ctr_adv), .ctr_load(ctr_load), .ctr_load_val(ctr_load_val)
    );

    function automatic logic [7:0] bmask(input int k);
        case (k)
            0: return 8'h3F; 1: return 8'h7F; 2: return 8'h7F; 3: return 8'h3F;
            4: return 8'h07; 5: return 8'h3F; 6: return 8'h1F; default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v == 8'h59)       return 8'h00;
        if (v[3:0] == 4'd9)   return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    assign ctr_now = {mdl[7], mdl[6], mdl[5], mdl[4], mdl[3], mdl[2], mdl[1], mdl[0]};

    // calendar counter model
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tick_512) tick_cnt <= tick_cnt + 1;
        if (!rst_n) begin
            mdl[0] <= 8'h20; mdl[1] <= 8'h58; mdl[2] <= 8'h59; mdl[3] <= 8'h23;
            mdl[4] <= 8'h05; mdl[5] <= 8'h31; mdl[6] <= 8'h12; mdl[7] <= 8'h99;
        end else if (ctr_load) begin
            for (int k = 0; k < 8; k++) mdl[k] <= ctr_load_val[k*8 +: 8];
        end else if (ctr_adv) begin
            mdl[1] <= bcd_inc(mdl[1]);
            if (mdl[1] == 8'h59) mdl[2] <= bcd_inc(mdl[2]);
        end
        if (ctr_adv) begin
            adv_cnt  <= adv_cnt + 1;
            adv_gap  <= cyc - last_adv;
            last_adv <= cyc;
        end
    end

    always @(negedge clk) begin
        tdiv     <= (tdiv == TPER - 1) ? 0 : tdiv + 1;
        tick_512 <= tick_en && (tdiv == 0);
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_adv();
        int n0 = adv_cnt;
        int lim = 0;
        while (adv_cnt == n0 && lim < 2000) begin
            @(negedge clk);
            lim++;
        end
        if (adv_cnt == n0) chk("R10 advance timeout", 0, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_tick();
        int t0 = tick_cnt;
        while (tick_cnt == t0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R2 load idle", ctr_load, 0);
        chk("R2 adv idle", ctr_adv, 0);
        for (int k = 0; k < 8; k++) begin
            rd(WBASE + AW'(k), v);
            chk("R2 reg reset", v, (k == 4) ? 8'h80 : 8'h00);
        end
    endtask

    task automatic t_sram();
        logic [7:0] v;
        wr(10'h000, 8'hA5);
        wr(10'h3F7, 8'h3C);
        wr(WBASE, 8'h00);
        rd(10'h3F7, v);
        chk("R1 sram below window", v, 8'h3C);
        rd(10'h000, v);
        chk("R1 sram low", v, 8'hA5);
    endtask

    task automatic t_refresh();
        logic [7:0] v;
        tick_en = 1;
        wait_adv();
        wait_adv();
        chk("R10 advance spacing", adv_gap, DIV * TPER);
        for (int k = 0; k < 8; k++) begin
            rd(WBASE + AW'(k), v);
            chk("R1 R3 register map", v, (k == 4) ? (8'h80 | (mdl[k] & bmask(k))) : (mdl[k] & bmask(k)));
        end
    endtask

    task automatic t_read_halt();
        logic [7:0] s0, v;
        wr(WBASE, 8'h60);
        rd(WBASE + 1, s0);
        wait_adv();
        wait_adv();
        rd(WBASE + 1, v);
        chk("R4 frozen seconds", v, s0);
        chk("R4 counter kept running", (mdl[1] != s0), 1);
        wr(WBASE, 8'h20);
        rd(WBASE + 1, v);
        chk("R4 no refresh before tick", v, s0);
        wait_adv();
        rd(WBASE + 1, v);
        chk("R4 refreshed after clear", v, mdl[1] & 8'h7F);
    endtask

    task automatic t_write_load();
        logic [7:0] v;
        wr(WBASE, 8'hA0);
        wr(WBASE + 1, 8'h10); wr(WBASE + 2, 8'h30); wr(WBASE + 3, 8'h07);
        wr(WBASE + 4, 8'h03); wr(WBASE + 5, 8'h15); wr(WBASE + 6, 8'h06);
        wr(WBASE + 7, 8'h24);
        wait_adv();
        rd(WBASE + 1, v);
        chk("R5 written value held", v, 8'h10);
        wr(WBASE, 8'h21);
        chk("R5 load pulse", ctr_load, 1);
        chk("R5 load values", ctr_load_val, 64'h24_06_15_03_07_30_10_21);
        @(negedge clk);
        chk("R5 load one cycle", ctr_load, 0);
        wait_adv();
        rd(WBASE + 1, v);
        chk("R5 counter resumed from load", v, 8'h11);
        // write halt wins over read halt
        wr(WBASE, 8'hE1);
        wr(WBASE + 1, 8'h40);
        wr(WBASE, 8'h61);
        chk("R5 load with read halt set", ctr_load, 1);
        chk("R5 loaded seconds", ctr_load_val[15:8], 8'h40);
        wait_adv();
        rd(WBASE + 1, v);
        chk("R5 read halt still frozen", v, 8'h40);
        wr(WBASE, 8'h21);
        chk("R5 no load without write halt", ctr_load, 0);
    endtask

    task automatic t_osc_stop();
        logic [7:0] v;
        int n0;
        wait_adv();
        wr(WBASE, 8'hA1);
        wr(WBASE + 1, 8'h85);
        wr(WBASE, 8'h21);
        chk("R6 load seconds", ctr_load_val[15:8], 8'h05);
        n0 = adv_cnt;
        repeat (200) @(negedge clk);
        chk("R6 no advance while stopped", adv_cnt, n0);
        rd(WBASE + 1, v);
        chk("R6 stop bit reads back", v, 8'h85);
        wr(WBASE + 1, 8'h05);
        wait_adv();
        rd(WBASE + 1, v);
        chk("R6 restarted", v, 8'h06);
    endtask

    task automatic t_ftest();
        logic [7:0] a, b;
        wr(WBASE + 4, 8'h43);
        wait_tick(); rd(WBASE + 1, a);
        wait_tick(); rd(WBASE + 1, b);
        chk("R7 lsb toggles per tick", a[0] ^ b[0], 1);
        wr(WBASE + 4, 8'h03);
        wait_adv();
        rd(WBASE + 1, a);
        wait_tick(); rd(WBASE + 1, b);
        chk("R7 lsb steady when off", b, a);
    endtask

    task automatic t_batt();
        logic [7:0] v;
        @(negedge clk) batt_ok = 1'b0;
        rd(WBASE + 4, v);
        chk("R8 flag low", v[7], 0);
        wr(WBASE + 4, 8'h83);
        rd(WBASE + 4, v);
        chk("R8 flag not writable", v[7], 0);
        @(negedge clk) batt_ok = 1'b1;
        wr(WBASE + 4, 8'h03);
        rd(WBASE + 4, v);
        chk("R8 flag high", v[7], 1);
    endtask

    task automatic t_spare();
        logic [7:0] v;
        wait_adv();
        wr(WBASE + 3, 8'h80);
        wr(WBASE + 5, 8'hC0);
        wait_adv();
        rd(WBASE + 3, v);
        chk("R9 hour spare kept", v, 8'h80 | (mdl[3] & 8'h3F));
        rd(WBASE + 5, v);
        chk("R9 date spare kept", v, 8'hC0 | (mdl[5] & 8'h3F));
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sram();
        t_refresh();
        t_read_halt();
        t_write_load();
        t_osc_stop();
        t_ftest();
        t_batt();
        t_spare();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule